// File: doc/BRIEF.md
# PWM Divider Parameter Calculator

This unit turns a requested PWM period and active time, both given as counts of source-clock cycles, into the four settings a downstream PWM generator needs. These are a power-of-two divider exponent, an 8-bit prescaler, a 16-bit entire-cycle field and a 16-bit active-cycle field. The exponent is found without a search: it is the bit length of the period divided by the constant 16,843,008 (that is 255*65537 + 2*65536 + 1). The unit then divides by 65537 to get the smallest prescaler, and clamps it at 255. All divisions share one iterative restoring divider. A state machine runs them one after another.

Some channels share a clock divider with a partner channel. When that partner is already running, the caller raises `partner_run` and supplies the exponent already in use on `ext_div`. The unit then computes only the prescaler and the two cycle fields. A request is made with a one-cycle `start`. Completion comes as a one-cycle `done` together with `err`. The outputs keep their values until the next computation finishes. A rejected request leaves them untouched.

States: S_IDLE waits for `start` and goes to S_FINISH when the request is invalid at once. Otherwise it goes to S_EXP_GO in normal mode or to S_PRE_GO in partner mode. Each division has a launch state and a wait state:
- S_EXP_GO and S_EXP_WT, for the exponent. A result above 8 goes to S_FINISH.
- S_PRE_GO and S_PRE_WT, for the prescaler.
- S_TICK_GO and S_TICK_WT, for the tick count. A bad count goes to S_FINISH.
- S_ACT_GO and S_ACT_WT, for the active field.

S_ACT_WT leads to S_FINISH. S_FINISH commits the results and returns to S_IDLE.

Top module: `pwm_div_calc`

## Requirements
- R1: In normal mode (`partner_run`=0) the exponent `div_exp` equals the bit length of floor(P / 16843008). The bit length is the index of the highest set bit plus one, and 0 for a zero value.
- R2: In partner mode (`partner_run`=1), `div_exp` equals `ext_div`. A value of `ext_div` above 8 is rejected with `err`=1. Any computed exponent above 8 is also rejected.
- R3: A requested period P of 0 or 1 is rejected with `err`=1 in either mode.
- R4: With S = P >> `div_exp`, the prescaler `prescale` equals min(floor(S / 65537), 255).
- R5: The tick count T is floor(S / (`prescale`+1)), and `entire_fld` = T − 1. A request with T = 0 or T > 65536 is rejected with `err`=1.
- R6: `active_fld` equals floor((D >> `div_exp`) / (`prescale`+1)), where D is the requested duty. It saturates at 65535.
- R7: Every accepted `start` produces exactly one `done` pulse, one cycle wide, and `err` is valid in that same cycle.
- R8: After a rejected request, `div_exp`, `prescale`, `entire_fld` and `active_fld` keep the values of the last successful request. All outputs hold between computations.
- R9: A `start` that arrives while a computation is in progress is ignored, and the running result is unchanged.
- R10: After reset, `done`, `err`, `div_exp`, `prescale`, `entire_fld` and `active_fld` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| partner_run | input | 1 | Partner channel running: take the exponent from `ext_div` |
| ext_div | input | 4 | Exponent already in use on the shared divider |
| period_cyc | input | 32 | Requested period in source-clock cycles |
| duty_cyc | input | 32 | Requested active time in source-clock cycles |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected, valid with `done` |
| div_exp | output | 4 | Power-of-two divider exponent |
| prescale | output | 8 | Prescaler value (divide by value+1) |
| entire_fld | output | 16 | Ticks per period minus one |
| active_fld | output | 16 | Active ticks per period |

## Verification
Random periods are drawn with a random right shift, so every exponent from 0 to 8 and both small and large prescalers appear. Random duties cover duty below, equal to and above the period, which separates active-field division from saturation.

Directed periods check the boundaries:
- 0, 1 and 2 separate rejection from the smallest legal period.
- 65536 and 65537 straddle the first prescaler step.
- 16843007 and 16843008 straddle the first exponent step. The first of these also exceeds the 65536-tick limit.

Partner-mode requests add exponents 9 to 15 and a tiny period with a large exponent, which yields zero ticks. A second `start` fired mid-computation shows whether the first request's result survives.

// File: rtl/pwm_div_pkg.sv
package pwm_div_pkg;
    localparam int unsigned DW        = 32;
    localparam int unsigned EXP_W     = 4;
    localparam int unsigned PRE_W     = 8;
    localparam int unsigned FLD_W     = 16;
    localparam logic [DW-1:0] EXP_DIVISOR = 32'd16843008;
    localparam logic [DW-1:0] PRE_DIVISOR = 32'd65537;
    localparam logic [DW-1:0] TICK_LIMIT  = 32'd65536;
    localparam logic [EXP_W-1:0] EXP_MAX  = 4'd8;

    typedef enum logic [3:0] {
        S_IDLE, S_EXP_GO, S_EXP_WT, S_PRE_GO, S_PRE_WT,
        S_TICK_GO, S_TICK_WT, S_ACT_GO, S_ACT_WT, S_FINISH
    } calc_state_t;
endpackage

// File: rtl/pwm_bitlen.sv
module pwm_bitlen #(
    parameter int unsigned W = 32,
    localparam int unsigned NW = $clog2(W + 1)
) (
    input  logic [W-1:0]  value,
    output logic [NW-1:0] length
);
    always_comb begin
        length = '0;
        for (int i = 0; i < int'(W); i++) begin
            if (value[i]) length = NW'(i + 1);
        end
    end
endmodule

// File: rtl/pwm_seq_divider.sv
module pwm_seq_divider #(
    parameter int unsigned W = 32,
    localparam int unsigned CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         fin,
    output logic [W-1:0] quotient
);
    logic [W-1:0]  rem_q, dvs_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic [W:0]    shifted, diff;

    assign shifted = {rem_q, quotient[W-1]};
    assign diff    = shifted - {1'b0, dvs_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q    <= '0;
            dvs_q    <= '0;
            quotient <= '0;
            cnt_q    <= '0;
            busy_q   <= 1'b0;
            fin      <= 1'b0;
        end else if (go && !busy_q) begin
            rem_q    <= '0;
            dvs_q    <= divisor;
            quotient <= dividend;
            cnt_q    <= CW'(W);
            busy_q   <= 1'b1;
            fin      <= 1'b0;
        end else if (busy_q) begin
            if (!diff[W]) begin
                rem_q    <= diff[W-1:0];
                quotient <= {quotient[W-2:0], 1'b1};
            end else begin
                rem_q    <= shifted[W-1:0];
                quotient <= {quotient[W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
                busy_q <= 1'b0;
                fin    <= 1'b1;
            end
        end else begin
            fin <= 1'b0;
        end
    end

    // R4: a finished division leaves a remainder below the divisor
    a_r4_div_remainder: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (rem_q < dvs_q));
    // R7: the divider result is a single-cycle event
    a_r7_div_fin_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);
endmodule

// File: rtl/pwm_div_calc.sv
module pwm_div_calc
    import pwm_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              partner_run,
    input  logic [EXP_W-1:0]  ext_div,
    input  logic [DW-1:0]     period_cyc,
    input  logic [DW-1:0]     duty_cyc,
    output logic              done,
    output logic              err,
    output logic [EXP_W-1:0]  div_exp,
    output logic [PRE_W-1:0]  prescale,
    output logic [FLD_W-1:0]  entire_fld,
    output logic [FLD_W-1:0]  active_fld
);
    localparam int unsigned BLW = $clog2(DW + 1);

    calc_state_t state_q, state_d;

    logic [DW-1:0]    per_q, dut_q;
    logic [EXP_W-1:0] exp_w;
    logic [PRE_W-1:0] pre_w;
    logic [FLD_W-1:0] ent_w, act_w;
    logic             err_w;

    logic             dv_go, dv_fin;
    logic [DW-1:0]    dv_num, dv_den, dv_q;
    logic [BLW-1:0]   q_len;
    logic [DW-1:0]    pre_plus1;
    logic             bad_now, exp_bad, tick_bad;

    pwm_seq_divider #(.W(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .go(dv_go),
        .dividend(dv_num), .divisor(dv_den),
        .fin(dv_fin), .quotient(dv_q)
    );

    pwm_bitlen #(.W(DW)) u_len (.value(dv_q), .length(q_len));

    assign pre_plus1 = {{(DW-PRE_W){1'b0}}, pre_w} + DW'(1);
    assign bad_now   = (period_cyc <= DW'(1)) || (partner_run && (ext_div > EXP_MAX));
    assign exp_bad   = q_len > BLW'(EXP_MAX);
    assign tick_bad  = (dv_q == '0) || (dv_q > TICK_LIMIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = bad_now ? S_FINISH :
                                           (partner_run ? S_PRE_GO : S_EXP_GO);
            S_EXP_GO:  state_d = S_EXP_WT;
            S_EXP_WT:  if (dv_fin) state_d = exp_bad ? S_FINISH : S_PRE_GO;
            S_PRE_GO:  state_d = S_PRE_WT;
            S_PRE_WT:  if (dv_fin) state_d = S_TICK_GO;
            S_TICK_GO: state_d = S_TICK_WT;
            S_TICK_WT: if (dv_fin) state_d = tick_bad ? S_FINISH : S_ACT_GO;
            S_ACT_GO:  state_d = S_ACT_WT;
            S_ACT_WT:  if (dv_fin) state_d = S_FINISH;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // divider operand selection
    always_comb begin
        dv_go  = 1'b0;
        dv_num = '0;
        dv_den = DW'(1);
        unique case (state_q)
            S_EXP_GO:  begin dv_go = 1'b1; dv_num = per_q;          dv_den = EXP_DIVISOR; end
            S_PRE_GO:  begin dv_go = 1'b1; dv_num = per_q >> exp_w; dv_den = PRE_DIVISOR; end
            S_TICK_GO: begin dv_go = 1'b1; dv_num = per_q >> exp_w; dv_den = pre_plus1;   end
            S_ACT_GO:  begin dv_go = 1'b1; dv_num = dut_q >> exp_w; dv_den = pre_plus1;   end
            default:   ;
        endcase
    end

    // working registers and committed outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= '0; dut_q <= '0;
            exp_w <= '0; pre_w <= '0; ent_w <= '0; act_w <= '0; err_w <= 1'b0;
            done <= 1'b0; err <= 1'b0;
            div_exp <= '0; prescale <= '0; entire_fld <= '0; active_fld <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start) begin
                    per_q <= period_cyc;
                    dut_q <= duty_cyc;
                    exp_w <= partner_run ? ext_div : '0;
                    err_w <= bad_now;
                end
                S_EXP_WT: if (dv_fin) begin
                    exp_w <= q_len[EXP_W-1:0];
                    err_w <= exp_bad;
                end
                S_PRE_WT: if (dv_fin)
                    pre_w <= (dv_q > DW'(255)) ? 8'hFF : dv_q[PRE_W-1:0];
                S_TICK_WT: if (dv_fin) begin
                    ent_w <= dv_q[FLD_W-1:0] - FLD_W'(1);
                    err_w <= tick_bad;
                end
                S_ACT_WT: if (dv_fin)
                    act_w <= (dv_q > DW'(65535)) ? 16'hFFFF : dv_q[FLD_W-1:0];
                S_FINISH: begin
                    done <= 1'b1;
                    err  <= err_w;
                    if (!err_w) begin
                        div_exp    <= exp_w;
                        prescale   <= pre_w;
                        entire_fld <= ent_w;
                        active_fld <= act_w;
                    end
                end
                default: ;
            endcase
        end
    end

    // R7: completion is one cycle wide
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2: a successful result never carries an exponent above the limit
    a_r2_exp_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (div_exp <= EXP_MAX));
    // R8: a rejected request leaves every field as it was
    a_r8_err_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> ($stable(div_exp) && $stable(prescale) &&
                           $stable(entire_fld) && $stable(active_fld)));
    // R9: latched request does not move while busy
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && start) |=> ($stable(per_q) && $stable(dut_q)));
    // R8: fields move only together with done
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(entire_fld) && $stable(active_fld)));
endmodule

// File: tb/sim_pwm_div_calc.sv
`timescale 1ns/1ps
module sim_pwm_div_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        partner_run = 1'b0;
    logic [3:0]  ext_div = '0;
    logic [31:0] period_cyc = '0;
    logic [31:0] duty_cyc = '0;
    logic        done, err;
    logic [3:0]  div_exp;
    logic [7:0]  prescale;
    logic [15:0] entire_fld, active_fld;

    int checks = 0;
    int errors = 0;
    logic [3:0]  g_exp = '0;
    logic [7:0]  g_pre = '0;
    logic [15:0] g_ent = '0, g_act = '0;

    always #2.5 clk = ~clk;

    pwm_div_calc u0 (.*);

    function automatic int blen(longint unsigned v);
        int n = 0;
        for (int i = 0; i < 64; i++) if (v[i]) n = i + 1;
        return n;
    endfunction

    task automatic chk(string req, longint unsigned act, longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(logic [31:0] p, logic [31:0] d, logic part, logic [3:0] ext, bit poke);
        longint unsigned s, pre, tick, act;
        int e;
        bit bad;
        bit seen = 0;
        bad = (p <= 1);
        e = part ? int'(ext) : blen(p / 64'd16843008);
        if (e > 8) bad = 1;
        if (!bad) begin
            s = longint'(p) >> e;
            pre = s / 65537; if (pre > 255) pre = 255;
            tick = s / (pre + 1);
            if (tick == 0 || tick > 65536) bad = 1;
            act = (longint'(d) >> e) / (pre + 1); if (act > 65535) act = 65535;
            if (!bad) begin
                g_exp = 4'(e); g_pre = 8'(pre); g_ent = 16'(tick - 1); g_act = 16'(act);
            end
        end
        @(negedge clk);
        period_cyc = p; duty_cyc = d; partner_run = part; ext_div = ext; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 400 && !seen; k++) begin
            if (poke && k == 3) begin
                period_cyc = 32'd2; duty_cyc = 32'd1; partner_run = 1'b0; start = 1'b1;
            end else start = 1'b0;
            @(negedge clk);
            if (done) seen = 1;
        end
        start = 1'b0;
        chk("R7 done seen", seen, 1);
        chk("R3/R2/R5 err", err, bad);
        chk("R1/R2 div_exp", div_exp, g_exp);
        chk("R4 prescale", prescale, g_pre);
        chk("R5 entire_fld", entire_fld, g_ent);
        chk("R6 active_fld", active_fld, g_act);
        @(negedge clk);
        chk("R7 done one cycle", done, 0);
        chk("R8 hold entire", entire_fld, g_ent);
    endtask

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R10 done", done, 0);
        chk("R10 err", err, 0);
        chk("R10 fields", {div_exp, prescale, entire_fld, active_fld}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run(32'd0, 32'd0, 0, 4'd0, 0);          // R3
        run(32'd1, 32'd1, 0, 4'd0, 0);          // R3
        run(32'd2, 32'd1, 0, 4'd0, 0);          // R5 smallest legal
        run(32'd65536, 32'd40000, 0, 4'd0, 0);  // R4 boundary
        run(32'd65537, 32'd70000, 0, 4'd0, 0);  // R4 boundary
        run(32'd16843007, 32'd5, 0, 4'd0, 0);   // R5 tick too large
        run(32'd16843008, 32'd16843008, 0, 4'd0, 0); // R1 step
        run(32'hFFFFFFFF, 32'hFFFFFFFF, 0, 4'd0, 0); // R1 top
        run(32'd1000, 32'd500, 1, 4'd9, 0);     // R2 ext too large
        run(32'd1000, 32'd500, 1, 4'd15, 0);    // R2
        run(32'd200, 32'd100, 1, 4'd8, 0);      // R5 zero ticks
        run(32'd900000, 32'd4000000, 1, 4'd3, 0); // R2, R6 duty above period
        run(32'd3000000, 32'd1000000, 0, 4'd0, 1); // R9 start while busy
        for (int i = 0; i < 60; i++) begin
            logic [31:0] p, d;
            logic part;
            p = $urandom() >> ($urandom() % 32);
            d = $urandom() >> ($urandom() % 32);
            part = ($urandom() % 4) == 0;
            run(p, d, part, 4'($urandom() % 11), ($urandom() % 8) == 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule